// File: doc/BRIEF.md
# Linear-Table Address Translator

This block sits between one client and memory and turns the client's virtual addresses into physical addresses. It looks each page up in a flat table in memory that holds one 32-bit word per 4 KiB page. The table starts at a programmable physical page. It covers a programmable window of virtual pages, described by a first page number and an inclusive page span. A four-entry, fully associative translation cache keeps recent page pairs, so repeated accesses to a page need no table read.

Software programs the table base, the window and two redirect pages through a small 32-bit register port. It does this with the translator switched off, then switches it on. Accesses outside the window, and accesses whose table word is zero, go to the redirect page for their direction (read or write) and raise a one-cycle fault flag. A bypass mode passes addresses through unchanged. Any write to the flush register empties the cache.

The client presents a request under a ready/valid handshake. A cache hit, a bypass or a redirect is accepted at once, and the response follows one cycle later. A miss holds `req_ready` low while a single table word is read. The request is then accepted from the refilled cache.

Top module: `lin_xlate`

## Requirements
- R1: The register port reads, at the byte offsets below, with unlisted offsets reading zero. Writes to offset 0x00 have no effect.
  - 0x00 reads constant 0x0000_0100: layout code 1 in bits 15:8.
  - 0x04 reads back only control bits 0 (translate on), 1 (gate open) and 4 (bypass).
  - 0x10 is the table base page.
  - 0x14 is the read redirect page.
  - 0x18 is the write redirect page.
  - 0x1C is the first window page.
  - 0x20 is the window span.
  - The five page registers hold 20-bit page numbers.
  - Offset 0x08 reads zero.
- R2: Unless control bits 0 and 1 are both set, `req_ready` stays low and no table read starts, whatever the client presents.
- R3: With bit 4 set (and bits 0, 1 set), a request is accepted at once and answered with `rsp_pa` equal to `req_va`, no fault and no table read.
- R4: A virtual page (address bits 31:12) is inside the window when first ≤ page ≤ first + span. Both ends are included. Outside it, the response is the redirect page for the direction (`req_wr`=1 write) joined with address bits 11:0, with the fault flag set.
- R5: The table word for an in-window page is read at address base×4096 + 4×(page − first).
- R6: On a cache miss, `req_ready` is low and `mem_req` rises the next cycle. `mem_addr` is held stable until `mem_rvalid`. The request is accepted in the cycle after the data returns. Bits 19:0 of `mem_rdata` are the physical page.
- R7: On a hit, the request is accepted in the cycle it is presented, and `rsp_valid` is high in the next cycle. `rsp_pa` is the cached page joined with address bits 11:0, with no table read.
- R8: A table word whose page field is zero is treated as unmapped. The response is redirected as in R4, by direction, with the fault flag set.
- R9: The cache holds 4 pages. Each fill replaces the oldest fill since the last flush or reset.
- R10: Any write to offset 0x08 empties the cache. A table read already in flight at that write does not fill the cache, and the request is fetched again.
- R11: `rsp_fault` is high only together with `rsp_valid`, and only for a redirected response. Every `rsp_valid` follows an accepted request.
- R12: After reset, all registers are zero, with `rsp_valid`, `req_ready` and `mem_req` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_va | input | 32 | Virtual address |
| req_wr | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Translation result valid |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 1 | Result was redirected to a default page |
| mem_req | output | 1 | Table word read outstanding |
| mem_addr | output | 32 | Byte address of the table word |
| mem_rvalid | input | 1 | Table word returned this cycle |
| mem_rdata | input | 32 | Table word |

## Verification
A wrong cache tag or a wrong round-robin pointer changes which request stalls. It shows at `req_ready` and `mem_req` in the very cycle the affected page is presented again, well before any data is wrong. A bad window bound or table base shows as a wrong `mem_addr` the cycle after the miss, or as a fault flag on the response one cycle after acceptance. A lost flush or stale fill shows only when the flushed page is used again, as a missing table read in that cycle. The stimulus therefore revisits pages after evictions and after flushes.

// File: rtl/lin_xlate_pkg.sv
// Shared constants for the linear-table translator: FSM states,
// register word indices and control bit positions.
package lin_xlate_pkg;

    typedef enum logic {XL_IDLE, XL_FETCH} xl_state_e;

    // Register word indices (byte offset >> 2); software depends on them
    localparam logic [3:0] RW_VERSION = 4'h0;
    localparam logic [3:0] RW_CTRL    = 4'h1;
    localparam logic [3:0] RW_FLUSH   = 4'h2;
    localparam logic [3:0] RW_TBASE   = 4'h4;
    localparam logic [3:0] RW_DFLT_RD = 4'h5;
    localparam logic [3:0] RW_DFLT_WR = 4'h6;
    localparam logic [3:0] RW_FIRST   = 4'h7;
    localparam logic [3:0] RW_SPAN    = 4'h8;

    localparam int CTRL_ON   = 0;
    localparam int CTRL_GATE = 1;
    localparam int CTRL_BYP  = 4;

    localparam logic [7:0] LAYOUT_ID = 8'h01;

endpackage

// File: rtl/lin_xlate_regs.sv
// Configuration register file.
// Holds control bits and the page-number registers, decodes the flush
// strobe and serves combinational read data.
// Assumes reg_addr is a byte offset; bits 1:0 are ignored.
module lin_xlate_regs
    import lin_xlate_pkg::*;
#(
    parameter int PN_W = 20,
    parameter int RA_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            xl_on,
    output logic            byp,
    output logic            flush,
    output logic [PN_W-1:0] base_ppn,
    output logic [PN_W-1:0] first_vpn,
    output logic [PN_W-1:0] vpn_span,
    output logic [PN_W-1:0] dflt_rd,
    output logic [PN_W-1:0] dflt_wr
);
    localparam int PAD = 32 - PN_W;
    localparam int WI_W = RA_W - 2;

    logic [WI_W-1:0] widx;
    logic            ctl_on, ctl_gate, ctl_byp;
    logic            unused_bits;

    assign widx        = reg_addr[RA_W-1:2];
    assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:PN_W]};

    // Capture writes into the control and page registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_on    <= 1'b0;
            ctl_gate  <= 1'b0;
            ctl_byp   <= 1'b0;
            base_ppn  <= '0;
            first_vpn <= '0;
            vpn_span  <= '0;
            dflt_rd   <= '0;
            dflt_wr   <= '0;
        end else if (reg_wr) begin
            if (widx == WI_W'(RW_CTRL)) begin
                ctl_on   <= reg_wdata[CTRL_ON];
                ctl_gate <= reg_wdata[CTRL_GATE];
                ctl_byp  <= reg_wdata[CTRL_BYP];
            end
            if (widx == WI_W'(RW_TBASE))   base_ppn  <= reg_wdata[PN_W-1:0];
            if (widx == WI_W'(RW_DFLT_RD)) dflt_rd   <= reg_wdata[PN_W-1:0];
            if (widx == WI_W'(RW_DFLT_WR)) dflt_wr   <= reg_wdata[PN_W-1:0];
            if (widx == WI_W'(RW_FIRST))   first_vpn <= reg_wdata[PN_W-1:0];
            if (widx == WI_W'(RW_SPAN))    vpn_span  <= reg_wdata[PN_W-1:0];
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (widx == WI_W'(RW_VERSION)) reg_rdata = {16'h0, LAYOUT_ID, 8'h0};
        if (widx == WI_W'(RW_CTRL))    reg_rdata = {27'h0, ctl_byp, 2'b00, ctl_gate, ctl_on};
        if (widx == WI_W'(RW_TBASE))   reg_rdata = {{PAD{1'b0}}, base_ppn};
        if (widx == WI_W'(RW_DFLT_RD)) reg_rdata = {{PAD{1'b0}}, dflt_rd};
        if (widx == WI_W'(RW_DFLT_WR)) reg_rdata = {{PAD{1'b0}}, dflt_wr};
        if (widx == WI_W'(RW_FIRST))   reg_rdata = {{PAD{1'b0}}, first_vpn};
        if (widx == WI_W'(RW_SPAN))    reg_rdata = {{PAD{1'b0}}, vpn_span};
    end

    assign xl_on = ctl_on & ctl_gate;
    assign byp   = ctl_byp;
    assign flush = reg_wr && (widx == WI_W'(RW_FLUSH));

endmodule

// File: rtl/lin_xlate_tlb.sv
// Fully associative page cache with round-robin fill.
// The lookup is combinational; fill and flush act at the clock edge.
// A flush beats a fill in the same cycle and restarts the fill pointer.
// Assumes the caller never fills a page that is already present.
module lin_xlate_tlb #(
    parameter int PN_W  = 20,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PN_W-1:0] look_vpn,
    output logic            hit,
    output logic [PN_W-1:0] hit_ppn,
    input  logic            fill,
    input  logic [PN_W-1:0] fill_vpn,
    input  logic [PN_W-1:0] fill_ppn,
    input  logic            flush
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0]            ptr;
    logic [DEPTH-1:0]            match;
    logic [DEPTH-1:0][PN_W-1:0]  sel_ppn;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic            v_r;
        logic [PN_W-1:0] tag_r, ppn_r;

        // Entry storage: cleared by flush, written when the pointer selects it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_r   <= 1'b0;
                tag_r <= '0;
                ppn_r <= '0;
            end else if (flush) begin
                v_r <= 1'b0;
            end else if (fill && ptr == PTR_W'(g)) begin
                v_r   <= 1'b1;
                tag_r <= fill_vpn;
                ppn_r <= fill_ppn;
            end
        end

        assign match[g]   = v_r && (tag_r == look_vpn);
        assign sel_ppn[g] = match[g] ? ppn_r : '0;
    end

    // Round-robin fill pointer
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            ptr <= '0;
        else if (fill)
            ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end

    // Merge the one matching entry's page
    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < DEPTH; i++) hit_ppn = hit_ppn | sel_ppn[i];
    end

    assign hit = |match;

endmodule

// File: rtl/lin_xlate.sv
// Linear-table address translator, top level.
// Handles the window check, the page-cache lookup, a single table-word
// fetch on a miss, redirects to default pages, and bypass.
// Assumes the client holds req_va/req_wr stable while req_valid waits,
// and that memory answers each mem_req with exactly one mem_rvalid.
module lin_xlate
    import lin_xlate_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int TLB_DEPTH  = 4,
    parameter int REG_AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic              req_wr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_fault,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);
    localparam int PN_W = ADDR_W - PAGE_SHIFT;

    xl_state_e         state;
    logic              xl_on, byp, flush;
    logic [PN_W-1:0]   base_ppn, first_vpn, vpn_span, dflt_rd, dflt_wr;
    logic [PN_W-1:0]   vpn, tlb_ppn, red_ppn, fetch_vpn;
    logic [PN_W:0]     rel;
    logic              in_win, tlb_hit, launch, accept, fill, stale;
    logic [ADDR_W-1:0] entry_addr, fetch_addr, nxt_pa;
    logic              nxt_fault;
    logic              unused_hi;

    lin_xlate_regs #(.PN_W(PN_W), .RA_W(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .xl_on     (xl_on),
        .byp       (byp),
        .flush     (flush),
        .base_ppn  (base_ppn),
        .first_vpn (first_vpn),
        .vpn_span  (vpn_span),
        .dflt_rd   (dflt_rd),
        .dflt_wr   (dflt_wr)
    );

    lin_xlate_tlb #(.PN_W(PN_W), .DEPTH(TLB_DEPTH)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_vpn (vpn),
        .hit      (tlb_hit),
        .hit_ppn  (tlb_ppn),
        .fill     (fill),
        .fill_vpn (fetch_vpn),
        .fill_ppn (mem_rdata[PN_W-1:0]),
        .flush    (flush)
    );

    assign unused_hi = ^mem_rdata[31:PN_W];

    // Window check and table-word address
    assign vpn        = req_va[ADDR_W-1:PAGE_SHIFT];
    assign rel        = {1'b0, vpn} - {1'b0, first_vpn};
    assign in_win     = !rel[PN_W] && (rel[PN_W-1:0] <= vpn_span);
    assign entry_addr = {base_ppn, {PAGE_SHIFT{1'b0}}} + (ADDR_W'(rel[PN_W-1:0]) << 2);
    assign red_ppn    = req_wr ? dflt_wr : dflt_rd;

    // Handshake: accept at once unless a table read is needed
    assign req_ready = (state == XL_IDLE) && xl_on && (byp || !in_win || tlb_hit);
    assign launch    = (state == XL_IDLE) && xl_on && req_valid && !byp && in_win && !tlb_hit;
    assign accept    = req_valid && req_ready;
    assign fill      = (state == XL_FETCH) && mem_rvalid && !stale && !flush;
    assign mem_req   = (state == XL_FETCH);
    assign mem_addr  = fetch_addr;

    // Result selection: bypass, redirect, or cached page
    always_comb begin
        nxt_fault = 1'b0;
        nxt_pa    = {tlb_ppn, req_va[PAGE_SHIFT-1:0]};
        if (byp) begin
            nxt_pa = req_va;
        end else if (!in_win || tlb_ppn == '0) begin
            nxt_pa    = {red_ppn, req_va[PAGE_SHIFT-1:0]};
            nxt_fault = 1'b1;
        end
    end

    // Response register: one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_fault <= accept && nxt_fault;
            if (accept) rsp_pa <= nxt_pa;
        end
    end

    // Fetch sequencer: launch on a miss, return to idle on data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= XL_IDLE;
            fetch_addr <= '0;
            fetch_vpn  <= '0;
        end else if (state == XL_IDLE) begin
            if (launch) begin
                state      <= XL_FETCH;
                fetch_addr <= entry_addr;
                fetch_vpn  <= vpn;
            end
        end else if (mem_rvalid) begin
            state <= XL_IDLE;
        end
    end

    // Mark an in-flight fetch stale when a flush lands on it
    always_ff @(posedge clk) begin
        if (!rst_n || launch)
            stale <= 1'b0;
        else if (flush)
            stale <= 1'b1;
    end

endmodule

// File: rtl/lin_xlate_chk.sv
// Protocol checker for lin_xlate, attached by bind.
// Assumes the synchronous active-low reset of the block.
module lin_xlate_chk #(
    parameter int ADDR_W = 32,
    parameter int REG_AW = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic              mem_req,
    input logic              mem_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              xl_on,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_rdata
);
    p_version_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == REG_AW'(0) |-> reg_rdata[15:8] == 8'h01);

    p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_on |-> !req_ready);

    p_fetch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    p_no_accept_in_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

    p_rsp_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));

    p_fault_with_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

endmodule

bind lin_xlate lin_xlate_chk #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .mem_addr   (mem_addr),
    .xl_on      (xl_on),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata)
);

// File: tb/lin_xlate_tb_top.sv
// Bench: behavioural reference model (queue-based cache, integer window
// arithmetic) compared against every output at each falling edge.
module lin_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_wr = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        rsp_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    lin_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_wr(req_wr),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 0;
    bit    done = 0;
    string g_tag = "R12";

    // ---------------- reference model state ----------------
    logic [31:0] m_cfg, m_base, m_first, m_range, m_drd, m_dwr;
    logic [31:0] m_faddr, m_fvpn, e_pa;
    bit          m_fetch, m_stale, e_rv, e_rf;
    string       e_tag = "R7";
    logic [31:0] q_vpn[$];
    logic [31:0] q_ppn[$];

    function automatic bit m_on();
        return m_cfg[0] && m_cfg[1];
    endfunction

    function automatic bit m_inwin(input logic [31:0] vpn);
        return (vpn >= m_first) && ((vpn - m_first) <= m_range);
    endfunction

    function automatic bit m_lookup(input logic [31:0] vpn, output logic [31:0] ppn);
        ppn = 0;
        foreach (q_vpn[i]) if (q_vpn[i] == vpn) begin ppn = q_ppn[i]; return 1; end
        return 0;
    endfunction

    function automatic bit exp_ready();
        logic [31:0] p;
        logic [31:0] vpn = req_va >> 12;
        if (!rst_n || m_fetch || !m_on()) return 0;
        return m_cfg[4] || !m_inwin(vpn) || m_lookup(vpn, p);
    endfunction

    function automatic logic [31:0] exp_rd();
        case (reg_addr[5:2])
            4'h0: return 32'h0000_0100;
            4'h1: return m_cfg & 32'h13;
            4'h4: return m_base;
            4'h5: return m_drd;
            4'h6: return m_dwr;
            4'h7: return m_first;
            4'h8: return m_range;
            default: return 0;
        endcase
    endfunction

    // Table contents in memory: word index low nibble 0xB is an empty entry
    function automatic logic [31:0] tbl(input logic [31:0] a);
        logic [31:0] w = a >> 2;
        if (w[3:0] == 4'hB) return 0;
        return 32'hABC0_0000 | (((w * 13) + 32'h321) & 32'hF_FFFF);
    endfunction

    // Reference model update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_base = 0; m_first = 0; m_range = 0; m_drd = 0; m_dwr = 0;
            m_fetch = 0; m_stale = 0; e_rv = 0; e_rf = 0; e_pa = 0;
            q_vpn.delete(); q_ppn.delete();
        end else begin
            logic [31:0] vpn, off, ppn, red;
            bit hit, rdy, flush;
            vpn   = req_va >> 12;
            off   = req_va & 32'hFFF;
            red   = req_wr ? m_dwr : m_drd;
            hit   = m_lookup(vpn, ppn);
            rdy   = exp_ready();
            flush = reg_wr && reg_addr[5:2] == 4'h2;
            e_rv = 0; e_rf = 0;
            if (req_valid && rdy) begin
                e_rv = 1;
                if (m_cfg[4]) begin e_pa = req_va; e_tag = "R3"; end
                else if (!m_inwin(vpn)) begin e_pa = (red << 12) | off; e_rf = 1; e_tag = "R4"; end
                else if (ppn == 0) begin e_pa = (red << 12) | off; e_rf = 1; e_tag = "R8"; end
                else begin e_pa = (ppn << 12) | off; e_tag = "R7"; end
            end
            if (m_fetch && mem_rvalid) begin
                m_fetch = 0;
                if (!m_stale && !flush) begin
                    if (q_vpn.size() == 4) begin void'(q_vpn.pop_front()); void'(q_ppn.pop_front()); end
                    q_vpn.push_back(m_fvpn);
                    q_ppn.push_back(mem_rdata & 32'hF_FFFF);
                end
            end else if (!m_fetch && m_on() && req_valid && !m_cfg[4] && m_inwin(vpn) && !hit) begin
                m_fetch = 1; m_stale = 0; m_fvpn = vpn;
                m_faddr = (m_base << 12) + ((vpn - m_first) << 2);
            end else if (flush) begin
                m_stale = 1;
            end
            if (flush) begin q_vpn.delete(); q_ppn.delete(); end
            if (reg_wr) begin
                case (reg_addr[5:2])
                    4'h1: m_cfg   = reg_wdata & 32'h13;
                    4'h4: m_base  = reg_wdata & 32'hF_FFFF;
                    4'h5: m_drd   = reg_wdata & 32'hF_FFFF;
                    4'h6: m_dwr   = reg_wdata & 32'hF_FFFF;
                    4'h7: m_first = reg_wdata & 32'hF_FFFF;
                    4'h8: m_range = reg_wdata & 32'hF_FFFF;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare every output at each falling edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(!rst_n ? "R12" : g_tag, "req_ready", 32'(req_ready), 32'(exp_ready()));
            chk(!rst_n ? "R12" : "R6", "mem_req", 32'(mem_req), 32'(m_fetch));
            if (m_fetch) chk("R5", "mem_addr", mem_addr, m_faddr);
            chk(!rst_n ? "R12" : "R7", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
            if (e_rv) chk(e_tag, "rsp_pa", rsp_pa, e_pa);
            chk("R11", "rsp_fault", 32'(rsp_fault), 32'(e_rf));
            chk(!rst_n ? "R12" : "R1", "reg_rdata", reg_rdata, exp_rd());
        end
    end

    // Memory responder: latency 2 + mem_addr[4:2] cycles
    int lat_cnt = 0;
    always @(posedge clk) begin
        #1;
        if (mem_rvalid) mem_rvalid = 1'b0;
        else if (rst_n && mem_req) begin
            lat_cnt++;
            if (lat_cnt >= 2 + int'(mem_addr[4:2])) begin
                mem_rvalid = 1'b1;
                mem_rdata  = tbl(mem_addr);
                lat_cnt    = 0;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] va, input bit wr);
        req_valid = 1'b1; req_va = va; req_wr = wr;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        cyc(1);
        req_valid = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(1);
        cmp_on = 1;                 // R12: reset values compared from here
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R2: held off with control bits clear, then with only one of them set
        g_tag = "R2";
        req_valid = 1'b1; req_va = 32'h0010_0ABC; req_wr = 1'b0;
        cyc(3);
        reg_write(6'h04, 32'h1);
        cyc(3);
        reg_write(6'h04, 32'h2);
        cyc(3);
        req_valid = 1'b0;
        reg_write(6'h04, 32'h0);

        // R1: program and read back the register set
        g_tag = "R1";
        reg_write(6'h10, 32'hFF08_0000);
        reg_write(6'h1C, 32'h0000_0100);
        reg_write(6'h20, 32'h0000_000F);
        reg_write(6'h14, 32'h0000_DEAD);
        reg_write(6'h18, 32'h0000_BEEF);
        reg_write(6'h00, 32'hFFFF_FFFF);
        reg_write(6'h04, 32'hFFFF_FFEF);
        for (int a = 0; a < 64; a += 4) begin reg_addr = 6'(a); cyc(1); end

        // R6, R5, R7: miss then hit on the same page
        g_tag = "R6";
        xlate(32'h0010_0ABC, 0);
        g_tag = "R7";
        xlate(32'h0010_0123, 1);
        xlate(32'h0010_0FFF, 0);

        // R4: window edges inside and just outside
        g_tag = "R4";
        xlate(32'h000F_F123, 0);
        xlate(32'h0011_0004, 1);
        xlate(32'h0010_F010, 1);
        xlate(32'h0010_F020, 0);

        // R8: empty table word, both directions
        g_tag = "R8";
        xlate(32'h0010_B444, 0);
        xlate(32'h0010_B555, 1);

        // R9: five fills after a flush, then revisit evicted and kept pages
        g_tag = "R9";
        reg_write(6'h08, 32'h0);
        for (int p = 1; p <= 5; p++) xlate(32'h0010_0000 | (p << 12), 0);
        xlate(32'h0010_1008, 0);
        xlate(32'h0010_3008, 1);
        xlate(32'h0010_2008, 0);

        // R10: flush empties the cache; a flush during a fetch drops its fill
        g_tag = "R10";
        reg_write(6'h08, 32'h1234);
        xlate(32'h0010_3008, 0);
        fork
            xlate(32'h0010_6000, 0);
            begin cyc(2); reg_write(6'h08, 32'h0); end
        join
        xlate(32'h0010_6004, 1);

        // R3: bypass passes addresses through
        g_tag = "R3";
        reg_write(6'h04, 32'h13);
        xlate(32'h1234_5678, 0);
        xlate(32'hFFFF_F001, 1);

        // R4: reprogram a full 256 MiB window starting at page zero
        g_tag = "R4";
        reg_write(6'h04, 32'h0);
        reg_write(6'h10, 32'h0007_FF00);
        reg_write(6'h1C, 32'h0);
        reg_write(6'h20, 32'h0000_FFFF);
        reg_write(6'h08, 32'h0);
        reg_write(6'h04, 32'h3);
        xlate(32'h0FFF_FFFC, 0);
        xlate(32'h1000_0000, 1);
        xlate(32'h0000_0010, 0);
        cyc(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule